// File: doc/BRIEF.md
# Site Update Accumulate-Scale-Subtract Stage

This block finishes the update of one lattice site. Eight partial result vectors sit in external buffers, each vector holding 24 signed fixed-point words (12 complex values, real and imaginary parts kept as separate words). The block sums the eight vectors element by element through a three-level reduction. The first level forms four pair sums, the second forms two, and the third forms one. It multiplies the total by a scaling constant and subtracts the product from the site's present vector. The new vector goes out through a write port.

All additions and subtractions share two adder pipes. Each pipe takes one operation per cycle and returns its result a fixed number of cycles later. One fully pipelined multiplier does the scaling. A control state machine sequences the operands and keeps every level from reading a partial sum before it exists. The states are ST_IDLE, ST_RED1, ST_WAIT1, ST_RED2, ST_WAIT2, ST_RED3, ST_WAIT3, ST_SCALE, ST_FLUSH and ST_DONE. The transitions are:
- ST_IDLE to ST_RED1 on start.
- Each ST_REDn to ST_WAITn when its last operation has been issued.
- Each ST_WAITn to the next level once the pipes are empty.
- ST_WAIT3 to ST_SCALE once the pipes are empty.
- ST_SCALE to ST_FLUSH after its last element.
- ST_FLUSH to ST_DONE once the pipes are empty.
- ST_DONE to ST_IDLE unconditionally.

The scaling constant is written through a configuration write before start. It has FRAC_W fraction bits.

Top module: `site_accum_scale_sub`

## Requirements
- R1: Out of reset, busy, done, res_we, part_rd_en and cur_rd_en are all 0.
- R2: A start seen in idle begins one update. A start seen while busy is ignored, so each run gives exactly N_ELEM writes and one done.
- R3: Partial buffers are read exactly 2·N_ELEM times per update, at element addresses 0,0,1,1,…,N_ELEM-1,N_ELEM-1 in consecutive order. Read data is expected one cycle after part_rd_en. Buffer k occupies part_rd_data[k·DATA_W +: DATA_W].
- R4: The partial sums of the four first-level pairs (0+1, 2+3, 4+5, 6+7), then of the two second-level pairs, then the final sum, are each fully formed before the next level reads them. Sums wrap modulo 2^DATA_W.
- R5: Each written element equals cur[e] − scale(Σk part[k][e], kappa), with all arithmetic in DATA_W-bit two's complement and wrapping.
- R6: scale(s,k) forms the full signed product s·k, adds 2^(FRAC_W−1), shifts right arithmetically by FRAC_W, and keeps the low DATA_W bits, so exact halves round upward.
- R7: Results are written one element per write cycle with res_addr ascending 0..N_ELEM−1, exactly N_ELEM writes per update.
- R8: A kappa write is taken only in idle. A write while busy leaves the constant used by the running and later updates unchanged.
- R9: done is high for exactly one cycle, after the last result write, in cycle 9·N_ELEM/2 + 4·ADD_LAT + MUL_LAT + 6 counted from the cycle start was accepted (152 at default parameters).
- R10: The current-value buffer is read exactly N_ELEM times, addresses ascending, only after all partial reads, with data expected one cycle after cur_rd_en. It is never read in the same cycle as the partial buffers.
- R11: One update issues exactly 8·N_ELEM adder operations and N_ELEM multiplications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update (taken in idle only) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_kappa_we | input | 1 | Load the scaling constant |
| cfg_kappa_data | input | DATA_W | Signed scaling constant, FRAC_W fraction bits |
| part_rd_en | output | 1 | Read strobe to all eight partial buffers |
| part_rd_addr | output | $clog2(N_ELEM) | Element address for the partial buffers |
| part_rd_data | input | 8·DATA_W | One word from each partial buffer |
| cur_rd_en | output | 1 | Read strobe to the current-value buffer |
| cur_rd_addr | output | $clog2(N_ELEM) | Element address for the current value |
| cur_rd_data | input | DATA_W | Current site value word |
| res_we | output | 1 | Result write strobe |
| res_addr | output | $clog2(N_ELEM) | Result element address |
| res_data | output | DATA_W | New site value word |

## Verification
The bench builds the block with its default parameters: 24 elements, 18-bit words, 12 fraction bits, adder latency 9 and multiplier latency 2. These are the latencies the schedule was sized for, so the 152-cycle completion point and the drain time of every barrier are exercised at their real lengths. An 18-bit word lets near-full-scale inputs force wrap in the reduction and the product. Twelve fraction bits let a constant of exactly ±0.5 land on the rounding half-point.

// File: rtl/sas_pkg.sv
package sas_pkg;

    localparam int NUM_PART = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RED1,
        ST_WAIT1,
        ST_RED2,
        ST_WAIT2,
        ST_RED3,
        ST_WAIT3,
        ST_SCALE,
        ST_FLUSH,
        ST_DONE
    } sas_state_e;

endpackage

// File: rtl/sas_add_pipe.sv
module sas_add_pipe #(
    parameter int W   = 18,
    parameter int LAT = 9,
    parameter int TW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sub,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_b,
    input  logic [TW-1:0]       in_tag,
    output logic                out_valid,
    output logic signed [W-1:0] out_data,
    output logic [TW-1:0]       out_tag,
    output logic                empty
);

    logic [LAT-1:0]        v_q;
    logic signed [W-1:0]   d_q [LAT];
    logic [TW-1:0]         t_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= in_valid;
        d_q[0] <= in_sub ? (in_a - in_b) : (in_a + in_b);
        t_q[0] <= in_tag;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) v_q[i] <= 1'b0;
            else        v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
            t_q[i] <= t_q[i-1];
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = d_q[LAT-1];
    assign out_tag   = t_q[LAT-1];
    assign empty     = ~|v_q;

endmodule

// File: rtl/sas_mul_pipe.sv
module sas_mul_pipe #(
    parameter int W    = 18,
    parameter int FRAC = 12,
    parameter int LAT  = 2,
    parameter int TW   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_k,
    input  logic [TW-1:0]       in_tag,
    output logic                out_valid,
    output logic signed [W-1:0] out_data,
    output logic [TW-1:0]       out_tag,
    output logic                empty
);

    function automatic logic signed [W-1:0] scale_round(
        input logic signed [W-1:0] a,
        input logic signed [W-1:0] k
    );
        logic signed [2*W-1:0] full;
        full = a * k;
        full = full + ((2*W)'(1) <<< (FRAC - 1));
        full = full >>> FRAC;
        return full[W-1:0];
    endfunction

    logic [LAT-1:0]      v_q;
    logic signed [W-1:0] d_q [LAT];
    logic [TW-1:0]       t_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= in_valid;
        d_q[0] <= scale_round(in_a, in_k);
        t_q[0] <= in_tag;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) v_q[i] <= 1'b0;
            else        v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
            t_q[i] <= t_q[i-1];
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = d_q[LAT-1];
    assign out_tag   = t_q[LAT-1];
    assign empty     = ~|v_q;

endmodule

// File: rtl/sas_seq.sv
module sas_seq
    import sas_pkg::*;
#(
    parameter int N_ELEM = 24,
    localparam int CW    = $clog2(2 * N_ELEM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pipes_empty,
    output sas_state_e    state,
    output logic [CW-1:0] cnt,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] LAST_L1 = CW'(2 * N_ELEM - 1);
    localparam logic [CW-1:0] LAST_L2 = CW'(N_ELEM - 1);
    localparam logic [CW-1:0] LAST_L3 = CW'(N_ELEM / 2 - 1);
    localparam logic [CW-1:0] LAST_SC = CW'(N_ELEM - 1);

    sas_state_e    state_d;
    logic [CW-1:0] cnt_d;

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_RED1;
            end
            ST_RED1: begin
                cnt_d = cnt + 1'b1;
                if (cnt == LAST_L1) begin
                    state_d = ST_WAIT1;
                    cnt_d   = '0;
                end
            end
            ST_WAIT1: if (pipes_empty) state_d = ST_RED2;
            ST_RED2: begin
                cnt_d = cnt + 1'b1;
                if (cnt == LAST_L2) begin
                    state_d = ST_WAIT2;
                    cnt_d   = '0;
                end
            end
            ST_WAIT2: if (pipes_empty) state_d = ST_RED3;
            ST_RED3: begin
                cnt_d = cnt + 1'b1;
                if (cnt == LAST_L3) begin
                    state_d = ST_WAIT3;
                    cnt_d   = '0;
                end
            end
            ST_WAIT3: if (pipes_empty) state_d = ST_SCALE;
            ST_SCALE: begin
                cnt_d = cnt + 1'b1;
                if (cnt == LAST_SC) begin
                    state_d = ST_FLUSH;
                    cnt_d   = '0;
                end
            end
            ST_FLUSH: if (pipes_empty) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

endmodule

// File: rtl/site_accum_scale_sub.sv
module site_accum_scale_sub
    import sas_pkg::*;
#(
    parameter int N_ELEM  = 24,
    parameter int DATA_W  = 18,
    parameter int FRAC_W  = 12,
    parameter int ADD_LAT = 9,
    parameter int MUL_LAT = 2,
    localparam int EW     = $clog2(N_ELEM),
    localparam int CW     = $clog2(2 * N_ELEM),
    localparam int TW     = EW + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       busy,
    output logic                       done,
    input  logic                       cfg_kappa_we,
    input  logic [DATA_W-1:0]          cfg_kappa_data,
    output logic                       part_rd_en,
    output logic [EW-1:0]              part_rd_addr,
    input  logic [NUM_PART*DATA_W-1:0] part_rd_data,
    output logic                       cur_rd_en,
    output logic [EW-1:0]              cur_rd_addr,
    input  logic [DATA_W-1:0]          cur_rd_data,
    output logic                       res_we,
    output logic [EW-1:0]              res_addr,
    output logic [DATA_W-1:0]          res_data
);

    localparam int FIN = TW - 1;

    sas_state_e    state;
    logic [CW-1:0] cnt;
    logic          pipes_empty;

    logic signed [DATA_W-1:0] kappa_q;
    logic signed [DATA_W-1:0] scr [4][N_ELEM];
    logic signed [DATA_W-1:0] pw  [NUM_PART];

    // first-level issue follows the buffer read by one cycle
    logic          l1_v;
    logic          l1_ph;
    logic [EW-1:0] l1_e;

    // adder pipe inputs and outputs
    logic                     a0_v, a1_v, a0_sub, a1_sub;
    logic signed [DATA_W-1:0] a0_a, a0_b, a1_a, a1_b;
    logic [TW-1:0]            a0_t, a1_t;
    logic                     o0_v, o1_v, e0, e1;
    logic signed [DATA_W-1:0] o0_d, o1_d;
    logic [TW-1:0]            o0_t, o1_t;

    // multiplier
    logic                     m_v, mo_v, m_empty;
    logic signed [DATA_W-1:0] m_a, mo_d, cur_al;
    logic [EW-1:0]            m_t, mo_t;

    logic [EW-1:0] ce, e_even, e_odd;

    sas_seq #(.N_ELEM(N_ELEM)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pipes_empty (pipes_empty),
        .state       (state),
        .cnt         (cnt),
        .busy        (busy),
        .done        (done)
    );

    // scaling constant: accepted in idle only
    always_ff @(posedge clk) begin
        if (!rst_n)                               kappa_q <= '0;
        else if (cfg_kappa_we && state == ST_IDLE) kappa_q <= cfg_kappa_data;
    end

    always_comb begin
        for (int k = 0; k < NUM_PART; k++) pw[k] = part_rd_data[k*DATA_W +: DATA_W];
    end

    assign ce     = cnt[EW-1:0];
    assign e_even = {cnt[EW-2:0], 1'b0};
    assign e_odd  = {cnt[EW-2:0], 1'b1};

    // buffer read strobes
    always_comb begin
        part_rd_en   = (state == ST_RED1);
        part_rd_addr = cnt[EW:1];
        cur_rd_en    = (state == ST_SCALE);
        cur_rd_addr  = ce;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l1_v <= 1'b0;
        else        l1_v <= (state == ST_RED1);
        l1_ph <= cnt[0];
        l1_e  <= cnt[EW:1];
    end

    // current value delayed to meet the multiplier output
    if (MUL_LAT > 1) begin : g_cur_dly
        logic signed [DATA_W-1:0] c_q [MUL_LAT-1];
        always_ff @(posedge clk) begin
            c_q[0] <= cur_rd_data;
            for (int i = 1; i < MUL_LAT - 1; i++) c_q[i] <= c_q[i-1];
        end
        assign cur_al = c_q[MUL_LAT-2];
    end else begin : g_cur_dir
        assign cur_al = cur_rd_data;
    end

    // multiplier issue during scaling
    always_comb begin
        m_v = (state == ST_SCALE);
        m_a = scr[0][ce];
        m_t = ce;
    end

    // adder operand sequencing
    always_comb begin
        a0_v = 1'b0; a0_sub = 1'b0; a0_a = '0; a0_b = '0; a0_t = '0;
        a1_v = 1'b0; a1_sub = 1'b0; a1_a = '0; a1_b = '0; a1_t = '0;
        if (l1_v) begin
            a0_v = 1'b1;
            a0_a = pw[l1_ph ? 4 : 0];
            a0_b = pw[l1_ph ? 5 : 1];
            a0_t = {1'b0, (l1_ph ? 2'd2 : 2'd0), l1_e};
            a1_v = 1'b1;
            a1_a = pw[l1_ph ? 6 : 2];
            a1_b = pw[l1_ph ? 7 : 3];
            a1_t = {1'b0, (l1_ph ? 2'd3 : 2'd1), l1_e};
        end else if (state == ST_RED2) begin
            a0_v = 1'b1;
            a0_a = scr[0][ce];
            a0_b = scr[1][ce];
            a0_t = {1'b0, 2'd0, ce};
            a1_v = 1'b1;
            a1_a = scr[2][ce];
            a1_b = scr[3][ce];
            a1_t = {1'b0, 2'd1, ce};
        end else if (state == ST_RED3) begin
            a0_v = 1'b1;
            a0_a = scr[0][e_even];
            a0_b = scr[1][e_even];
            a0_t = {1'b0, 2'd0, e_even};
            a1_v = 1'b1;
            a1_a = scr[0][e_odd];
            a1_b = scr[1][e_odd];
            a1_t = {1'b0, 2'd0, e_odd};
        end else if (mo_v) begin
            if (mo_t[0]) begin
                a1_v = 1'b1; a1_sub = 1'b1;
                a1_a = cur_al; a1_b = mo_d;
                a1_t = {1'b1, 2'd0, mo_t};
            end else begin
                a0_v = 1'b1; a0_sub = 1'b1;
                a0_a = cur_al; a0_b = mo_d;
                a0_t = {1'b1, 2'd0, mo_t};
            end
        end
    end

    sas_add_pipe #(.W(DATA_W), .LAT(ADD_LAT), .TW(TW)) u_add0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(a0_v), .in_sub(a0_sub), .in_a(a0_a), .in_b(a0_b), .in_tag(a0_t),
        .out_valid(o0_v), .out_data(o0_d), .out_tag(o0_t), .empty(e0)
    );

    sas_add_pipe #(.W(DATA_W), .LAT(ADD_LAT), .TW(TW)) u_add1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(a1_v), .in_sub(a1_sub), .in_a(a1_a), .in_b(a1_b), .in_tag(a1_t),
        .out_valid(o1_v), .out_data(o1_d), .out_tag(o1_t), .empty(e1)
    );

    sas_mul_pipe #(.W(DATA_W), .FRAC(FRAC_W), .LAT(MUL_LAT), .TW(EW)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .in_valid(m_v), .in_a(m_a), .in_k(kappa_q), .in_tag(m_t),
        .out_valid(mo_v), .out_data(mo_d), .out_tag(mo_t), .empty(m_empty)
    );

    assign pipes_empty = e0 & e1 & m_empty & ~l1_v;

    // partial sums land in the scratch array
    always_ff @(posedge clk) begin
        if (o0_v && !o0_t[FIN]) scr[o0_t[FIN-1:FIN-2]][o0_t[EW-1:0]] <= o0_d;
        if (o1_v && !o1_t[FIN]) scr[o1_t[FIN-1:FIN-2]][o1_t[EW-1:0]] <= o1_d;
    end

    // final differences go out through the write port
    always_comb begin
        res_we   = 1'b0;
        res_addr = '0;
        res_data = '0;
        if (o0_v && o0_t[FIN]) begin
            res_we   = 1'b1;
            res_addr = o0_t[EW-1:0];
            res_data = o0_d;
        end else if (o1_v && o1_t[FIN]) begin
            res_we   = 1'b1;
            res_addr = o1_t[EW-1:0];
            res_data = o1_d;
        end
    end

endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
    parameter int N_ELEM  = 24,
    parameter int DATA_W  = 18,
    parameter int ADD_LAT = 9,
    parameter int MUL_LAT = 2,
    localparam int EW     = $clog2(N_ELEM)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              res_we,
    input logic [EW-1:0]     res_addr,
    input logic              part_rd_en,
    input logic              cur_rd_en,
    input logic [DATA_W-1:0] kappa_q,
    input logic              add0_v,
    input logic              add1_v,
    input logic              mul_v
);

    localparam int BUDGET = (9 * N_ELEM) / 2 + 4 * ADD_LAT + MUL_LAT + 6;

    logic [15:0] cyc_q, add_q, mul_q, wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            cyc_q <= '0;
            add_q <= '0;
            mul_q <= '0;
            wr_q  <= '0;
        end else begin
            cyc_q <= cyc_q + 16'd1;
            add_q <= add_q + 16'(add0_v) + 16'(add1_v);
            mul_q <= mul_q + 16'(mul_v);
            wr_q  <= wr_q + 16'(res_we);
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!res_we && !part_rd_en && !cur_rd_en));

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(part_rd_en && cur_rd_en));

    a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (int'(res_addr) < N_ELEM));

    a_r7_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(wr_q) == N_ELEM));

    a_r8_kappa_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(kappa_q));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_budget: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(cyc_q) == BUDGET - 1));

    a_r11_add_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(add_q) == 8 * N_ELEM));

    a_r11_mul_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(mul_q) == N_ELEM));

endmodule

bind site_accum_scale_sub sas_checker #(
    .N_ELEM(N_ELEM), .DATA_W(DATA_W), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .res_we(res_we), .res_addr(res_addr),
    .part_rd_en(part_rd_en), .cur_rd_en(cur_rd_en),
    .kappa_q(kappa_q), .add0_v(a0_v), .add1_v(a1_v), .mul_v(m_v)
);

// File: tb/site_accum_scale_sub_bench.sv
`timescale 1ns/1ps
module site_accum_scale_sub_bench;

    localparam int N   = 24;
    localparam int W   = 18;
    localparam int F   = 12;
    localparam int AL  = 9;
    localparam int ML  = 2;
    localparam int EW  = $clog2(N);
    localparam int BUDGET = (9 * N) / 2 + 4 * AL + ML + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done;
    logic cfg_kappa_we = 1'b0;
    logic [W-1:0] cfg_kappa_data = '0;
    logic part_rd_en, cur_rd_en, res_we;
    logic [EW-1:0] part_rd_addr, cur_rd_addr, res_addr;
    logic [8*W-1:0] part_rd_data = '0;
    logic [W-1:0] cur_rd_data = '0;
    logic [W-1:0] res_data;

    always #2 clk = ~clk;

    site_accum_scale_sub #(
        .N_ELEM(N), .DATA_W(W), .FRAC_W(F), .ADD_LAT(AL), .MUL_LAT(ML)
    ) u_site_accum_scale_sub (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .cfg_kappa_we(cfg_kappa_we), .cfg_kappa_data(cfg_kappa_data),
        .part_rd_en(part_rd_en), .part_rd_addr(part_rd_addr), .part_rd_data(part_rd_data),
        .cur_rd_en(cur_rd_en), .cur_rd_addr(cur_rd_addr), .cur_rd_data(cur_rd_data),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data)
    );

    logic signed [W-1:0] pmem [8][N];
    logic signed [W-1:0] cmem [N];
    logic signed [W-1:0] kap_model;
    logic [W-1:0] exp_q [$];

    int n_checks = 0, n_fail = 0;
    int wr_idx = 0, part_cnt = 0, cur_cnt = 0, rd_err = 0, stray = 0;
    int unsigned seed = 32'h1234_5678;

    // buffer models, one-cycle read latency
    always @(posedge clk) begin
        if (part_rd_en)
            for (int k = 0; k < 8; k++) part_rd_data[k*W +: W] <= pmem[k][part_rd_addr];
        if (cur_rd_en) cur_rd_data <= cmem[cur_rd_addr];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: read-order tracking and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (part_rd_en) begin
                if (int'(part_rd_addr) != part_cnt / 2) rd_err++;
                part_cnt++;
            end
            if (cur_rd_en) begin
                if (int'(cur_rd_addr) != cur_cnt || part_cnt != 2 * N) rd_err++;
                cur_cnt++;
            end
            if (res_we) begin
                if (exp_q.size() == 0) begin
                    stray++;
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(int'(res_addr) == wr_idx, "R7 addr", res_addr, wr_idx);
                    check(res_data == e, "R5 data", $signed(res_data), $signed(e));
                end
                wr_idx++;
            end
        end
    end

    function automatic logic [W-1:0] model(input int e, input logic signed [W-1:0] k);
        logic signed [W-1:0]   s;
        logic signed [2*W-1:0] p;
        s = '0;
        for (int i = 0; i < 8; i++) s = s + pmem[i][e];
        p = s * k;
        p = p + ((2*W)'(1) <<< (F - 1));
        p = p >>> F;
        return cmem[e] - p[W-1:0];
    endfunction

    function automatic logic [W-1:0] nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[30:13];
    endfunction

    task automatic fill_random();
        for (int e = 0; e < N; e++) begin
            for (int k = 0; k < 8; k++) pmem[k][e] = nxt();
            cmem[e] = nxt();
        end
    endtask

    task automatic load_kappa(input logic signed [W-1:0] k);
        @(negedge clk);
        cfg_kappa_we = 1'b1;
        cfg_kappa_data = k;
        @(negedge clk);
        cfg_kappa_we = 1'b0;
    endtask

    task automatic run_update(input string name);
        int n;
        for (int e = 0; e < N; e++) exp_q.push_back(model(e, kap_model));
        wr_idx = 0; part_cnt = 0; cur_cnt = 0; rd_err = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == BUDGET, {"R9 done cycle ", name}, n, BUDGET);
        check(wr_idx == N, {"R9 writes before done ", name}, wr_idx, N);
        check(part_cnt == 2 * N, {"R3 partial reads ", name}, part_cnt, 2 * N);
        check(cur_cnt == N, {"R10 current reads ", name}, cur_cnt, N);
        check(rd_err == 0, {"R3/R10 read order ", name}, rd_err, 0);
        check(exp_q.size() == 0, {"R7 pending results ", name}, exp_q.size(), 0);
        @(negedge clk);
        check(!done, {"R9 done one cycle ", name}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);
        check(!res_we, "R1 res_we", res_we, 0);
        check(!part_rd_en && !cur_rd_en, "R1 read strobes", part_rd_en | cur_rd_en, 0);

        // R5 random data, kappa = +0.5
        fill_random();
        kap_model = 18'sd2048;
        load_kappa(kap_model);
        run_update("rand_half");

        // R5 second pattern, kappa = -1.375
        fill_random();
        kap_model = -18'sd5632;
        load_kappa(kap_model);
        run_update("rand_neg");

        // R5 kappa zero leaves the current value
        fill_random();
        kap_model = '0;
        load_kappa(kap_model);
        run_update("kappa_zero");

        // R6 rounding at the half point: sum = 1
        for (int e = 0; e < N; e++) begin
            for (int k = 0; k < 8; k++) pmem[k][e] = (k == 3) ? 18'sd1 : 18'sd0;
            cmem[e] = 18'sd100;
        end
        kap_model = 18'sd2048;
        load_kappa(kap_model);
        check(model(0, kap_model) == 18'd99, "R6 +0.5 rounds up", model(0, kap_model), 99);
        run_update("round_pos");
        kap_model = -18'sd2048;
        load_kappa(kap_model);
        check(model(0, kap_model) == 18'd100, "R6 -0.5 rounds up", model(0, kap_model), 100);
        run_update("round_neg");

        // R4 wrap in the reduction and product
        for (int e = 0; e < N; e++) begin
            for (int k = 0; k < 8; k++) pmem[k][e] = 18'sd131071 - 18'(e * 97 + k);
            cmem[e] = -18'sd131072 + 18'(e);
        end
        kap_model = -18'sd4096;
        load_kappa(kap_model);
        run_update("wrap");

        // R8 kappa write while busy is ignored
        fill_random();
        kap_model = 18'sd1000;
        load_kappa(kap_model);
        fork
            run_update("kappa_busy");
            begin
                repeat (40) @(negedge clk);
                cfg_kappa_we = 1'b1;
                cfg_kappa_data = 18'sd7777;
                @(negedge clk);
                cfg_kappa_we = 1'b0;
            end
        join
        fill_random();
        run_update("kappa_kept");

        // R2 start while busy is ignored
        fill_random();
        fork
            run_update("restart");
            begin
                repeat (60) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (200) @(negedge clk);
        check(!busy, "R2 idle after run", busy, 0);
        check(stray == 0, "R2 no extra writes", stray, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule